// File: doc/BRIEF.md
# Parallel Flash Page Read Controller

This block sits on the host side of a byte-wide parallel flash device and reads from one page of it. A single-cycle `start` pulse carries a request: the read mode (whole page or spare area only), a 16-bit sector number, a start column and a byte count. Requests that would run past the end of the selected area are refused at once. An accepted request runs a fixed bus sequence. The block drops chip-enable and writes the mode command with command-latch high. It then writes the sector number as two bytes and, for a whole-page read that does not start at column 0, two column bytes. Next it waits for the device to signal busy and then ready. After that it pulses the serial clock once per byte and delivers each sampled byte on a `rd_valid`/`rd_data` stream. It ends every operation by writing the termination command and raising chip-enable.

During a whole-page read the host may ask for a column jump. The controller stops the serial clock and raises output-enable. It writes two new column bytes, leaving the sector alone, and then goes on from the new column with the bytes still owed. If the device never signals busy or never returns to ready within a timeout, the controller flags an error and still terminates cleanly. All pulse widths and the timeout are parameters in system-clock cycles. A single down-counter times every interval.

States: IDLE, CMD, SEC_LO, SEC_HI, COL_LO, COL_HI, WAIT_BUSY, WAIT_RDY, SC_HI, SC_LO, END. Transitions:
- IDLE→CMD on an accepted start.
- CMD→SEC_LO→SEC_HI.
- SEC_HI→COL_LO for a whole-page read with a nonzero column, otherwise SEC_HI→WAIT_BUSY.
- COL_LO→COL_HI.
- COL_HI→WAIT_BUSY, or COL_HI→SC_HI when the column bytes belong to a jump.
- WAIT_BUSY→WAIT_RDY when busy is seen.
- WAIT_RDY→SC_HI when ready is seen.
- WAIT_BUSY or WAIT_RDY→END on timeout.
- SC_HI→SC_LO.
- SC_LO→SC_HI for the next byte, SC_LO→COL_LO for an accepted jump, or SC_LO→END when no bytes remain.
- END→IDLE.

Each write state has a strobe-low phase followed by a strobe-high phase.

Top module: `fpr_page_reader`

## Requirements
- R1: A start is rejected, with `rejected` high for one cycle and no bus activity (`ce_n` stays 1), when `byte_cnt` is 0. It is also rejected in whole-page mode (`mode_spare`=0) when `start_col`+`byte_cnt` exceeds 2112, and in spare mode (`mode_spare`=1) when `byte_cnt` exceeds 64.
- R2: An accepted read drives `ce_n` low and writes command 8'h00 (whole page) or 8'hF0 (spare) with `cle`=1. It then writes the sector low byte and the sector high byte with `cle`=0. Each byte is latched on the rising edge of `we_n`, and `dq_out` and `cle` stay stable while `we_n` is low.
- R3: After the sector bytes, two column bytes (bits 7:0, then bits 11:8 in the low nibble) are written only in whole-page mode with `start_col` not 0. Otherwise exactly two address bytes are written.
- R4: No serial-clock pulse is issued before `rb_n` has been seen low and then high after the address bytes, and `sc` is never high while `rb_n` is low.
- R5: Exactly `byte_cnt` serial-clock pulses are issued, each with `oe_n` low. The byte on `dq_in` is captured at the end of the high phase and presented with a one-cycle `rd_valid`. In spare mode the stream starts at page column 2048.
- R6: In whole-page mode, a `jump_req` pulse during the data phase with `jump_col`+remaining bytes ≤ 2112 causes two column bytes to be written with `oe_n` high after the current byte. Reading then continues from `jump_col` with the same total byte count.
- R7: A jump request is ignored (reading continues sequentially) in spare mode, or when `jump_col` plus the remaining byte count exceeds 2112.
- R8: Every accepted operation ends by writing 8'hFF with `cle`=1, then raising `ce_n`, with `done` high for one cycle in the same cycle `ce_n` returns to 1.
- R9: If `rb_n` does not go low, or does not return high, within `T_TO` cycles, `err_timeout` is set and no data is transferred. The 8'hFF termination and `done` still follow. `err_timeout` holds until the next accepted start.
- R10: Every `we_n` low pulse lasts exactly `T_WP` cycles, and every `sc` high pulse lasts exactly `T_SCH` cycles.
- R11: While `rst_n` is low, `res_n` is 0, `ce_n` and `we_n` are 1, and `sc` and `busy` are 0. `res_n` rises once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| mode_spare | input | 1 | 0 = whole page, 1 = spare area only |
| sector | input | 16 | Sector number |
| start_col | input | 12 | First column (whole-page mode) |
| byte_cnt | input | 12 | Bytes to read |
| jump_req | input | 1 | Column jump request pulse |
| jump_col | input | 12 | Target column of a jump |
| rb_n | input | 1 | Device ready (1) / busy (0) |
| dq_in | input | 8 | Device data bus, read direction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, one cycle |
| rejected | output | 1 | Request refused, one cycle |
| err_timeout | output | 1 | Ready/busy wait timed out |
| rd_valid | output | 1 | Read byte valid, one cycle |
| rd_data | output | 8 | Read byte |
| ce_n | output | 1 | Device chip-enable, active low |
| cle | output | 1 | Command latch enable |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| sc | output | 1 | Serial read clock |
| res_n | output | 1 | Device reset, active low |
| dq_out | output | 8 | Device data bus, write direction |
| dq_oe | output | 1 | Drive enable for `dq_out` |

## Verification
A corrupted remaining-byte counter shows up as one serial-clock pulse too many or too few. The stream length differs from the request by the end of the operation, and an over-run pulse reads invalid data past the page limit. A wrong column register or jump latch makes the byte stream diverge from the device model's column-addressed pattern at the first byte after the faulty write cycle. A state machine that skips the ready handshake pulses `sc` while the device is busy, which is caught on that very cycle. A timer loaded with the wrong value changes a strobe width, which is caught at the strobe's trailing edge.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_SEC_LO,
        ST_SEC_HI,
        ST_COL_LO,
        ST_COL_HI,
        ST_WAIT_BUSY,
        ST_WAIT_RDY,
        ST_SC_HI,
        ST_SC_LO,
        ST_END
    } fpr_state_e;

    localparam logic [7:0] OPC_READ_PAGE  = 8'h00;
    localparam logic [7:0] OPC_READ_SPARE = 8'hF0;
    localparam logic [7:0] OPC_TERMINATE  = 8'hFF;
endpackage

// File: rtl/fpr_timer.sv
module fpr_timer #(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fpr_span_check.sv
module fpr_span_check #(
    parameter int W = 12
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] count,
    input  logic [W:0]   limit,
    output logic         ok
);
    logic [W:0] span;

    assign span = {1'b0, base} + {1'b0, count};
    assign ok   = (count != '0) && (span <= limit);
endmodule

// File: rtl/fpr_page_reader.sv
module fpr_page_reader
    import fpr_pkg::*;
#(
    parameter int MAIN_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int T_WP        = 2,
    parameter int T_WPH       = 2,
    parameter int T_SCH       = 3,
    parameter int T_SCL       = 2,
    parameter int T_TO        = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mode_spare,
    input  logic [15:0] sector,
    input  logic [11:0] start_col,
    input  logic [11:0] byte_cnt,
    input  logic        jump_req,
    input  logic [11:0] jump_col,
    input  logic        rb_n,
    input  logic [7:0]  dq_in,
    output logic        busy,
    output logic        done,
    output logic        rejected,
    output logic        err_timeout,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        ce_n,
    output logic        cle,
    output logic        we_n,
    output logic        oe_n,
    output logic        sc,
    output logic        res_n,
    output logic [7:0]  dq_out,
    output logic        dq_oe
);
    localparam int CW        = 12;
    localparam int PAGE      = MAIN_BYTES + SPARE_BYTES;
    localparam int T_A       = (T_WP  > T_WPH) ? T_WP  : T_WPH;
    localparam int T_B       = (T_SCH > T_SCL) ? T_SCH : T_SCL;
    localparam int T_C       = (T_A   > T_B)   ? T_A   : T_B;
    localparam int TMAX      = (T_TO  > T_C)   ? T_TO  : T_C;
    localparam int TW        = $clog2(TMAX + 1);

    fpr_state_e    state, nxt;
    logic          wph, mode_q, jumping, jpend;
    logic [15:0]   sec_q;
    logic [CW-1:0] col_q, jcol_q, remain;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          req_ok, jump_ok, is_wr, to_hit, res_n_q;
    logic [15:0]   col_wide;

    // request and jump span checks
    fpr_span_check #(.W(CW)) u_req_chk (
        .base  (mode_spare ? '0 : start_col),
        .count (byte_cnt),
        .limit (mode_spare ? (CW+1)'(SPARE_BYTES) : (CW+1)'(PAGE)),
        .ok    (req_ok)
    );

    fpr_span_check #(.W(CW)) u_jump_chk (
        .base  (jcol_q),
        .count (remain),
        .limit ((CW+1)'(PAGE)),
        .ok    (jump_ok)
    );

    fpr_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign is_wr  = (state == ST_CMD) || (state == ST_SEC_LO) || (state == ST_SEC_HI) ||
                    (state == ST_COL_LO) || (state == ST_COL_HI) || (state == ST_END);
    assign to_hit = tmr_zero && (((state == ST_WAIT_BUSY) && rb_n) ||
                                 ((state == ST_WAIT_RDY) && !rb_n));

    function automatic logic [TW-1:0] entry_time(fpr_state_e s);
        unique case (s)
            ST_WAIT_BUSY, ST_WAIT_RDY: entry_time = TW'(T_TO - 1);
            ST_SC_HI:                  entry_time = TW'(T_SCH - 1);
            ST_SC_LO:                  entry_time = TW'(T_SCL - 1);
            ST_IDLE:                   entry_time = '0;
            default:                   entry_time = TW'(T_WP - 1);
        endcase
    endfunction

    // next state and timer control
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start && req_ok) nxt = ST_CMD;
            ST_CMD:       if (tmr_zero && wph) nxt = ST_SEC_LO;
            ST_SEC_LO:    if (tmr_zero && wph) nxt = ST_SEC_HI;
            ST_SEC_HI:    if (tmr_zero && wph)
                              nxt = (!mode_q && col_q != '0) ? ST_COL_LO : ST_WAIT_BUSY;
            ST_COL_LO:    if (tmr_zero && wph) nxt = ST_COL_HI;
            ST_COL_HI:    if (tmr_zero && wph) nxt = jumping ? ST_SC_HI : ST_WAIT_BUSY;
            ST_WAIT_BUSY: if (!rb_n) nxt = ST_WAIT_RDY; else if (tmr_zero) nxt = ST_END;
            ST_WAIT_RDY:  if (rb_n)  nxt = ST_SC_HI;    else if (tmr_zero) nxt = ST_END;
            ST_SC_HI:     if (tmr_zero) nxt = ST_SC_LO;
            ST_SC_LO:     if (tmr_zero) begin
                              if (remain == '0)                nxt = ST_END;
                              else if (jpend && !mode_q && jump_ok) nxt = ST_COL_LO;
                              else                             nxt = ST_SC_HI;
                          end
            ST_END:       if (tmr_zero && wph) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (nxt != state) begin
            tmr_load = 1'b1;
            tmr_val  = entry_time(nxt);
        end else if (is_wr && tmr_zero && !wph) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(T_WPH - 1);
        end
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            wph         <= 1'b0;
            mode_q      <= 1'b0;
            sec_q       <= '0;
            col_q       <= '0;
            jcol_q      <= '0;
            remain      <= '0;
            jumping     <= 1'b0;
            jpend       <= 1'b0;
            done        <= 1'b0;
            rejected    <= 1'b0;
            err_timeout <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            res_n_q     <= 1'b0;
        end else begin
            state    <= nxt;
            done     <= 1'b0;
            rejected <= 1'b0;
            rd_valid <= 1'b0;
            res_n_q  <= 1'b1;
            if (is_wr && tmr_zero) wph <= !wph;
            if (state == ST_IDLE && start) begin
                if (req_ok) begin
                    mode_q      <= mode_spare;
                    sec_q       <= sector;
                    col_q       <= mode_spare ? '0 : start_col;
                    remain      <= byte_cnt;
                    err_timeout <= 1'b0;
                    jumping     <= 1'b0;
                    jpend       <= 1'b0;
                end else begin
                    rejected <= 1'b1;
                end
            end
            if (jump_req && !jpend && (state == ST_SC_HI || state == ST_SC_LO)) begin
                jpend  <= 1'b1;
                jcol_q <= jump_col;
            end
            if (state == ST_SC_HI && tmr_zero) begin
                rd_valid <= 1'b1;
                rd_data  <= dq_in;
                remain   <= remain - 1'b1;
                jumping  <= 1'b0;
            end
            if (state == ST_SC_LO && tmr_zero) begin
                jpend <= 1'b0;
                if (nxt == ST_COL_LO) begin
                    jumping <= 1'b1;
                    col_q   <= jcol_q;
                end
            end
            if (to_hit) err_timeout <= 1'b1;
            if (state == ST_END && tmr_zero && wph) done <= 1'b1;
        end
    end

    assign col_wide = 16'(col_q);

    // pin decode
    always_comb begin
        busy   = (state != ST_IDLE);
        ce_n   = (state == ST_IDLE);
        cle    = (state == ST_CMD) || (state == ST_END);
        we_n   = !(is_wr && !wph);
        dq_oe  = is_wr;
        oe_n   = !((state == ST_SC_HI) || (state == ST_SC_LO));
        sc     = (state == ST_SC_HI);
        res_n  = res_n_q;
        unique case (state)
            ST_CMD:    dq_out = mode_q ? OPC_READ_SPARE : OPC_READ_PAGE;
            ST_SEC_LO: dq_out = sec_q[7:0];
            ST_SEC_HI: dq_out = sec_q[15:8];
            ST_COL_LO: dq_out = col_wide[7:0];
            ST_COL_HI: dq_out = col_wide[15:8];
            ST_END:    dq_out = OPC_TERMINATE;
            default:   dq_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/fpr_checker.sv
module fpr_checker #(
    parameter int T_WP  = 2,
    parameter int T_SCH = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       we_n,
    input logic       sc,
    input logic       oe_n,
    input logic       ce_n,
    input logic       cle,
    input logic       rb_n,
    input logic       rejected,
    input logic       done,
    input logic       err_timeout,
    input logic       rd_valid,
    input logic [7:0] dq_out
);
    int we_run, sc_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= 0;
            sc_run <= 0;
        end else begin
            we_run <= we_n ? 0 : we_run + 1;
            sc_run <= sc   ? sc_run + 1 : 0;
        end
    end

    p_reject_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> ce_n);
    p_dq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(dq_out) && $stable(cle)));
    p_sc_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sc |-> rb_n);
    p_sc_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sc |-> (!oe_n && !ce_n));
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ce_n);
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (!rd_valid && !sc));
    p_we_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run == T_WP));
    p_sc_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sc) |-> (sc_run == T_SCH));
endmodule

bind fpr_page_reader fpr_checker #(.T_WP(T_WP), .T_SCH(T_SCH)) u_fpr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_n        (we_n),
    .sc          (sc),
    .oe_n        (oe_n),
    .ce_n        (ce_n),
    .cle         (cle),
    .rb_n        (rb_n),
    .rejected    (rejected),
    .done        (done),
    .err_timeout (err_timeout),
    .rd_valid    (rd_valid),
    .dq_out      (dq_out)
);

// File: tb/test_fpr_page_reader.sv
module test_fpr_page_reader;
    localparam int T_WP  = 2;
    localparam int T_SCH = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, mode_spare = 1'b0, jump_req = 1'b0;
    logic [15:0] sector = '0;
    logic [11:0] start_col = '0, byte_cnt = '0, jump_col = '0;
    logic rb_n = 1'b1;
    logic [7:0] dq_in = '0;
    logic busy, done, rejected, err_timeout, rd_valid, ce_n, cle, we_n, oe_n, sc, res_n, dq_oe;
    logic [7:0] rd_data, dq_out;

    fpr_page_reader i_fpr_page_reader (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int c);
        return 8'((s * 7) + (c * 13) + (c >> 5));
    endfunction

    // flash device model
    logic prev_we = 1'b1, prev_sc = 1'b0;
    int m_cmd = -1, m_last = -1, m_idx = 0, m_naddr = 0, m_sector = 0, m_col = 0, m_lo = 0;
    int m_dly = 0, m_busy = 0, m_early = 0, m_we_bad = 0, m_sc_bad = 0, m_we_run = 0, m_sc_run = 0;
    bit m_reading = 0, m_hang = 0;

    always @(posedge clk) begin
        if (we_n && !prev_we) begin
            if (m_we_run != T_WP) m_we_bad++;
            if (cle) begin
                m_last = dq_out;
                m_reading = 0;
                if (dq_out != 8'hFF) begin
                    m_cmd = dq_out; m_idx = 0; m_naddr = 0;
                    m_col = (dq_out == 8'hF0) ? 2048 : 0;
                end
            end else begin
                if (m_idx == 0)          m_sector = dq_out;
                else if (m_idx == 1)     m_sector = m_sector | (int'(dq_out) << 8);
                else if (m_idx % 2 == 0) m_lo = dq_out;
                else                     m_col = ((int'(dq_out) & 15) << 8) | m_lo;
                m_idx++;
                if (!m_reading) begin m_naddr++; m_dly = 6; end
            end
        end
        if (m_dly > 0) begin
            m_dly--;
            if (m_dly == 0 && !m_hang) m_busy = 8;
        end else if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) m_reading = 1;
        end
        rb_n <= (m_busy == 0);
        if (sc && !prev_sc) begin
            if (!m_reading) m_early++;
            dq_in <= pat(m_sector, m_col);
            m_col++;
        end
        if (!sc && prev_sc && m_sc_run != T_SCH) m_sc_bad++;
        m_we_run = we_n ? 0 : m_we_run + 1;
        m_sc_run = sc ? m_sc_run + 1 : 0;
        prev_we = we_n;
        prev_sc = sc;
    end

    // stream collector and jump driver
    logic [7:0] got [0:4095];
    int n_got = 0, jump_at = 0;
    always @(negedge clk) begin
        jump_req <= 1'b0;
        if (rd_valid) begin
            got[n_got] = rd_data;
            n_got++;
            if (n_got == jump_at) jump_req <= 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic run(input bit md, input int sec, input int col, input int cnt,
                       input int jat, input int jcol, input bit hang);
        int t = 0, base, bad = 0, first_bad = -1, exp_b = 0, act_b = 0;
        bit ok, jacc;
        m_hang = hang; n_got = 0; jump_at = jat;
        m_cmd = -1; m_last = -1; m_early = 0;
        @(negedge clk);
        mode_spare = md; sector = 16'(sec); start_col = 12'(col);
        byte_cnt = 12'(cnt); jump_col = 12'(jcol); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(done || rejected) && t < 40000) begin @(negedge clk); t++; end
        ok = (cnt != 0) && (md ? cnt <= 64 : col + cnt <= 2112);
        if (!ok) begin
            chk(rejected, "R1 rejected", rejected, 1);
            repeat (4) @(negedge clk);
            chk(ce_n && n_got == 0 && m_cmd == -1, "R1 no bus activity", n_got, 0);
        end else if (hang) begin
            chk(done && err_timeout, "R9 timeout flag", err_timeout, 1);
            chk(n_got == 0, "R9 no data", n_got, 0);
            chk(m_last == 8'hFF && ce_n, "R9 R8 terminate", m_last, 255);
        end else begin
            chk(done && !err_timeout, "R8 done", done, 1);
            chk(m_last == 8'hFF && ce_n, "R8 terminate", m_last, 255);
            chk(m_cmd == (md ? 8'hF0 : 8'h00), "R2 command", m_cmd, md ? 240 : 0);
            chk(m_naddr == ((!md && col != 0) ? 4 : 2), "R3 address bytes", m_naddr,
                (!md && col != 0) ? 4 : 2);
            chk(m_early == 0, "R4 sc before ready", m_early, 0);
            chk(n_got == cnt, "R5 byte count", n_got, cnt);
            base = md ? 2048 : col;
            jacc = !md && jat > 0 && jat < cnt && jcol + (cnt - jat) <= 2112;
            for (int i = 0; i < n_got && i < cnt; i++) begin
                int c = (jacc && i >= jat) ? jcol + (i - jat) : base + i;
                if (got[i] != pat(sec, c)) begin
                    bad++;
                    if (first_bad < 0) begin first_bad = i; exp_b = pat(sec, c); act_b = got[i]; end
                end
            end
            if (jat > 0) chk(bad == 0, jacc ? "R6 jump data" : "R7 jump ignored", act_b, exp_b);
            else         chk(bad == 0, "R5 data", act_b, exp_b);
        end
        m_hang = 0;
    endtask

    initial begin
        int seed, md, col, cnt, lim, jat, jcol;
        seed = $urandom(20240611);
        repeat (3) @(negedge clk);
        chk(ce_n && we_n && !sc && !busy && !res_n, "R11 reset state", res_n, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(res_n && ce_n, "R11 res_n released", res_n, 1);

        run(0, 16'h1234, 0, 2112, 0, 0, 0);
        run(0, 16'h0042, 2111, 1, 0, 0, 0);
        run(0, 16'h0042, 2000, 113, 0, 0, 0);
        run(0, 16'h0042, 5, 0, 0, 0, 0);
        run(1, 16'hBEEF, 0, 64, 0, 0, 0);
        run(1, 16'hBEEF, 0, 65, 0, 0, 0);
        run(0, 16'h0777, 100, 10, 3, 2000, 0);
        run(0, 16'h0777, 100, 30, 10, 2100, 0);
        run(1, 16'h0707, 0, 20, 5, 10, 0);
        run(0, 16'h0101, 7, 12, 0, 0, 1);

        for (int k = 0; k < 16; k++) begin
            md  = ($urandom % 4 == 0);
            lim = md ? 64 : 2112;
            col = md ? 0 : $urandom % 2112;
            cnt = 1 + ($urandom % ((lim - col) < 200 ? (lim - col) : 200));
            if ($urandom % 6 == 0) cnt = lim - col + 1 + ($urandom % 5);
            jat = 0; jcol = 0;
            if ($urandom % 3 == 0 && cnt > 2) begin
                jat  = 1 + ($urandom % (cnt - 1));
                jcol = $urandom % 2112;
            end
            run(md[0], $urandom % 65536, col, cnt, jat, jcol, 0);
        end

        chk(m_we_bad == 0, "R10 we_n width", m_we_bad, 0);
        chk(m_sc_bad == 0, "R10 sc width", m_sc_bad, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule